// File: doc/BRIEF.md
# Write Window Block State Tracker

This block keeps the modification state of every block of one active flash write window. A host-side command decoder passes it an operation code, a block offset and count relative to the window, the window size in blocks and a no-erase hint. The block answers each operation with a result code. Each block carries one combined mark: clean, dirty (erase and program), dirty with no erase (program only) or erased. A separate lock bit per block lives alongside the marks.

A flush or a close walks the blocks in ascending order. For each marked block that is not locked it offers one write-back request, with a valid/ready handshake, to a flash engine. When the walk is done it clears every mark and leaves the locks in place. A discard clears the marks with no write-back, as happens when the window is reset. A combinational read query reports whether a byte address inside the window lands in an erased block, so that the memory path can return 0xFF for it. The block size is a power of two given as a shift, and the shift is never taken below 12.

Top module: `wbt_tracker`

## Requirements
- R1: After reset every block is clean and unlocked, `opReady` is 1, and `opDone`, `reqValid` and `rdErased` are 0.
- R2: A mark-dirty, mark-erased or lock operation returns result 2 and changes no state when offset plus count exceeds `winBlocks` or when `winBlocks` exceeds the block capacity. A range that ends exactly at `winBlocks` is accepted.
- R3: Mark-dirty (code 1) or mark-erased (code 2) over a range that holds any locked block returns result 9 and changes no state.
- R4: Lock (code 3) over a range that holds any dirty or erased block returns result 2 and changes nothing. Otherwise it returns 1 and locks every block in the range.
- R5: A successful mark returns result 1. Mark-dirty sets each block to erase-then-program, or to program-only when `opNoErase` is 1. Mark-erased sets each block to erased. A later mark replaces an earlier one. `opDone` pulses for one cycle in the cycle after acceptance.
- R6: `rdErased` is 1 exactly when block `rdAddr >> max(blkShift,12)` lies inside the capacity and is marked erased.
- R7: Flush (code 4) and close (code 5) issue one request per marked, unlocked block in ascending block order. `reqKind` is 1 for erase, 2 for program and 3 for erase-then-program, and `reqAddr` is the block index shifted left by the effective shift. A request holds until `reqReady`. After the last block, `opDone` pulses with result 1, every mark is cleared and every lock is kept.
- R8: Discard (code 6) clears every mark with no request and returns result 1.
- R9: Unlock-all (code 7) clears every lock and returns 1. Opcode 0 returns result 2 and changes nothing.
- R10: `opReady` is 0 from the acceptance of a flush or close until its `opDone`. An operation presented while `opReady` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation present |
| opCode | input | 3 | Operation code (0 to 7) |
| opOffset | input | CNT_W | First block, relative to the window |
| opCount | input | CNT_W | Number of blocks |
| opNoErase | input | 1 | Mark-dirty without a preceding erase |
| winBlocks | input | CNT_W | Window size in blocks |
| opReady | output | 1 | Tracker can accept an operation |
| opDone | output | 1 | One-cycle completion pulse |
| opResult | output | 8 | Result code: 1 success, 2 parameter error, 9 locked error |
| reqValid | output | 1 | Write-back request present |
| reqReady | input | 1 | Flash engine takes the request |
| reqBlock | output | IDX_W | Block index of the request |
| reqKind | output | 2 | Request kind: bit 0 erase, bit 1 program |
| reqAddr | output | ADDR_W | Byte offset of the requested block |
| blkShift | input | SHIFT_W | Block size as a shift |
| rdAddr | input | ADDR_W | Byte offset of a read within the window |
| rdErased | output | 1 | Read hits an erased block (return 0xFF) |

## Verification
Two functions can meet in one cycle: the read-override query and the end of a flush walk, which clears the marks at the same edge that raises `opDone`. A second case is an operation held on the inputs while the walk is still running. The bench parks `rdAddr` on an erased block during a flush that the flash engine stalls at random, and keeps a mark-erased operation on the inputs for the whole walk. It then expects `rdErased` to stay 1 up to the cycle before `opDone` and to fall exactly with it. It also expects the held operation to produce no completion and no mark, because the operation is dropped in the same cycle that the tracker becomes ready again.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

  typedef enum logic [2:0] {
    OP_NONE        = 3'd0,
    OP_MARK_DIRTY  = 3'd1,
    OP_MARK_ERASED = 3'd2,
    OP_LOCK        = 3'd3,
    OP_FLUSH       = 3'd4,
    OP_CLOSE       = 3'd5,
    OP_DISCARD     = 3'd6,
    OP_UNLOCK_ALL  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    MK_CLEAN   = 2'd0,
    MK_DIRTY   = 2'd1,
    MK_NOERASE = 2'd2,
    MK_ERASED  = 2'd3
  } mark_e;

  typedef enum logic {
    ST_IDLE,
    ST_SCAN
  } state_e;

  localparam logic [7:0] RES_OK     = 8'd1;
  localparam logic [7:0] RES_PARAM  = 8'd2;
  localparam logic [7:0] RES_LOCKED = 8'd9;

  localparam logic [1:0] KIND_ERASE = 2'b01;
  localparam logic [1:0] KIND_PROG  = 2'b10;
  localparam logic [1:0] KIND_BOTH  = 2'b11;

  typedef struct packed {
    logic applyDirty;
    logic applyErased;
    logic applyLock;
    logic clearMarks;
    logic clearLocks;
    logic scanClear;
    logic scanStep;
  } strobe_t;

endpackage

// File: rtl/wbt_datapath.sv
module wbt_datapath
  import wbt_pkg::*;
#(
  parameter int MAX_BLOCKS = 64,
  parameter int ADDR_W     = 28,
  parameter int SHIFT_W    = 5,
  parameter int MIN_SHIFT  = 12,
  parameter int CNT_W      = 7,
  parameter int IDX_W      = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [CNT_W-1:0]   opOffset,
  input  logic [CNT_W-1:0]   opCount,
  input  logic               opNoErase,
  input  logic [CNT_W-1:0]   winBlocks,
  input  logic [SHIFT_W-1:0] blkShift,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic               rangeBad,
  output logic               hitLocked,
  output logic               hitMarked,
  output logic               scanNeed,
  output logic               scanLast,
  output logic [IDX_W-1:0]   scanIdx,
  output logic [1:0]         scanKind,
  output logic [ADDR_W-1:0]  scanAddr,
  output logic               rdErased
);

  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] offExt, endExt, winExt;
  mark_e            markQ [MAX_BLOCKS];
  logic [MAX_BLOCKS-1:0] lockQ, inRng, marked;
  logic [IDX_W-1:0]   scanQ;
  logic [SHIFT_W-1:0] shiftEff;
  logic [ADDR_W-1:0]  rdBlk;
  mark_e              scanMark;

  assign offExt = {1'b0, opOffset};
  assign endExt = offExt + {1'b0, opCount};
  assign winExt = {1'b0, winBlocks};
  assign rangeBad = (endExt > winExt) || (winExt > SUM_W'(MAX_BLOCKS));

  generate
    for (genvar i = 0; i < MAX_BLOCKS; i++) begin : g_blk
      assign inRng[i]  = (SUM_W'(i) >= offExt) && (SUM_W'(i) < endExt);
      assign marked[i] = (markQ[i] != MK_CLEAN);
    end
  endgenerate

  assign hitLocked = |(inRng & lockQ);
  assign hitMarked = |(inRng & marked);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_BLOCKS; i++) markQ[i] <= MK_CLEAN;
    end else begin
      for (int i = 0; i < MAX_BLOCKS; i++) begin
        if (strb.clearMarks)
          markQ[i] <= MK_CLEAN;
        else if (inRng[i] && strb.applyDirty)
          markQ[i] <= opNoErase ? MK_NOERASE : MK_DIRTY;
        else if (inRng[i] && strb.applyErased)
          markQ[i] <= MK_ERASED;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= '0;
    end else if (strb.clearLocks) begin
      lockQ <= '0;
    end else if (strb.applyLock) begin
      lockQ <= lockQ | inRng;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               scanQ <= '0;
    else if (strb.scanClear) scanQ <= '0;
    else if (strb.scanStep)  scanQ <= scanQ + 1'b1;
  end

  assign scanIdx  = scanQ;
  assign scanLast = (scanQ == IDX_W'(MAX_BLOCKS - 1));
  assign scanMark = markQ[scanQ];
  assign scanNeed = (scanMark != MK_CLEAN) && !lockQ[scanQ];

  always_comb begin
    case (scanMark)
      MK_DIRTY:   scanKind = KIND_BOTH;
      MK_NOERASE: scanKind = KIND_PROG;
      MK_ERASED:  scanKind = KIND_ERASE;
      default:    scanKind = 2'b00;
    endcase
  end

  assign shiftEff = (blkShift < SHIFT_W'(MIN_SHIFT)) ? SHIFT_W'(MIN_SHIFT) : blkShift;
  assign scanAddr = ADDR_W'(scanQ) << shiftEff;
  assign rdBlk    = rdAddr >> shiftEff;
  assign rdErased = (rdBlk < ADDR_W'(MAX_BLOCKS)) && (markQ[rdBlk[IDX_W-1:0]] == MK_ERASED);

endmodule

// File: rtl/wbt_ctrl.sv
module wbt_ctrl
  import wbt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       rangeBad,
  input  logic       hitLocked,
  input  logic       hitMarked,
  input  logic       scanNeed,
  input  logic       scanLast,
  input  logic       reqReady,
  output strobe_t    strb,
  output logic       opReady,
  output logic       opDone,
  output logic [7:0] opResult,
  output logic       reqValid
);

  state_e     stateQ, stateD;
  logic       accept, goScan, finish, stepOk;
  logic [7:0] resD;

  assign opReady = (stateQ == ST_IDLE);
  assign accept  = opValid && opReady;
  assign stepOk  = !scanNeed || reqReady;
  assign reqValid = (stateQ == ST_SCAN) && scanNeed;

  always_comb begin
    strb   = '0;
    resD   = RES_OK;
    goScan = 1'b0;
    finish = 1'b0;
    stateD = stateQ;
    if (stateQ == ST_IDLE) begin
      if (accept) begin
        case (op_e'(opCode))
          OP_MARK_DIRTY, OP_MARK_ERASED: begin
            if (rangeBad)       resD = RES_PARAM;
            else if (hitLocked) resD = RES_LOCKED;
            else begin
              strb.applyDirty  = (op_e'(opCode) == OP_MARK_DIRTY);
              strb.applyErased = (op_e'(opCode) == OP_MARK_ERASED);
            end
          end
          OP_LOCK: begin
            if (rangeBad || hitMarked) resD = RES_PARAM;
            else strb.applyLock = 1'b1;
          end
          OP_FLUSH, OP_CLOSE: begin
            goScan         = 1'b1;
            strb.scanClear = 1'b1;
            stateD         = ST_SCAN;
          end
          OP_DISCARD:    strb.clearMarks = 1'b1;
          OP_UNLOCK_ALL: strb.clearLocks = 1'b1;
          default:       resD = RES_PARAM;
        endcase
      end
    end else begin
      if (stepOk) begin
        if (scanLast) begin
          finish          = 1'b1;
          strb.clearMarks = 1'b1;
          stateD          = ST_IDLE;
        end else begin
          strb.scanStep = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      opDone   <= 1'b0;
      opResult <= 8'd0;
    end else begin
      stateQ <= stateD;
      opDone <= (accept && !goScan) || finish;
      if (accept && !goScan) opResult <= resD;
      else if (finish)       opResult <= RES_OK;
    end
  end

endmodule

// File: rtl/wbt_tracker.sv
module wbt_tracker
  import wbt_pkg::*;
#(
  parameter int MAX_BLOCKS = 64,
  parameter int ADDR_W     = 28,
  parameter int SHIFT_W    = 5,
  parameter int MIN_SHIFT  = 12,
  localparam int CNT_W     = $clog2(MAX_BLOCKS + 1),
  localparam int IDX_W     = $clog2(MAX_BLOCKS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic [2:0]         opCode,
  input  logic [CNT_W-1:0]   opOffset,
  input  logic [CNT_W-1:0]   opCount,
  input  logic               opNoErase,
  input  logic [CNT_W-1:0]   winBlocks,
  output logic               opReady,
  output logic               opDone,
  output logic [7:0]         opResult,
  output logic               reqValid,
  input  logic               reqReady,
  output logic [IDX_W-1:0]   reqBlock,
  output logic [1:0]         reqKind,
  output logic [ADDR_W-1:0]  reqAddr,
  input  logic [SHIFT_W-1:0] blkShift,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic               rdErased
);

  strobe_t strb;
  logic rangeBad, hitLocked, hitMarked, scanNeed, scanLast;

  wbt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opCode   (opCode),
    .rangeBad (rangeBad),
    .hitLocked(hitLocked),
    .hitMarked(hitMarked),
    .scanNeed (scanNeed),
    .scanLast (scanLast),
    .reqReady (reqReady),
    .strb     (strb),
    .opReady  (opReady),
    .opDone   (opDone),
    .opResult (opResult),
    .reqValid (reqValid)
  );

  wbt_datapath #(
    .MAX_BLOCKS(MAX_BLOCKS),
    .ADDR_W    (ADDR_W),
    .SHIFT_W   (SHIFT_W),
    .MIN_SHIFT (MIN_SHIFT),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opOffset (opOffset),
    .opCount  (opCount),
    .opNoErase(opNoErase),
    .winBlocks(winBlocks),
    .blkShift (blkShift),
    .rdAddr   (rdAddr),
    .rangeBad (rangeBad),
    .hitLocked(hitLocked),
    .hitMarked(hitMarked),
    .scanNeed (scanNeed),
    .scanLast (scanLast),
    .scanIdx  (reqBlock),
    .scanKind (reqKind),
    .scanAddr (reqAddr),
    .rdErased (rdErased)
  );

endmodule

// File: rtl/wbt_checker.sv
module wbt_checker #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [2:0]       opCode,
  input logic             opReady,
  input logic             opDone,
  input logic [7:0]       opResult,
  input logic             reqValid,
  input logic             reqReady,
  input logic [IDX_W-1:0] reqBlock,
  input logic [1:0]       reqKind,
  input logic             rdErased
);

  assert_mark_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opReady && (opCode == 3'd1 || opCode == 3'd2 || opCode == 3'd3)) |=> opDone);

  assert_result_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> (opResult == 8'd1 || opResult == 8'd2 || opResult == 8'd9));

  assert_flush_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opReady && (opCode == 3'd4 || opCode == 3'd5)) |=> !opReady);

  assert_req_in_walk_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !opReady);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqBlock) && $stable(reqKind)));

  assert_req_kind_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqKind != 2'b00));

  assert_req_ascending_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqValid || (reqBlock > $past(reqBlock))));

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && $past(!opReady)) |-> !rdErased);

endmodule

bind wbt_tracker wbt_checker #(.IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opCode  (opCode),
  .opReady (opReady),
  .opDone  (opDone),
  .opResult(opResult),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqBlock(reqBlock),
  .reqKind (reqKind),
  .rdErased(rdErased)
);

// File: tb/tb_wbt_tracker.sv
module tb_wbt_tracker;

  localparam int MAXB  = 64;
  localparam int CNT_W = 7;
  localparam int IDX_W = 6;
  localparam int AW    = 28;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opCode = '0;
  logic [CNT_W-1:0] opOffset = '0, opCount = '0, winBlocks = 7'd16;
  logic opNoErase = 1'b0;
  logic opReady, opDone, reqValid, rdErased;
  logic reqReady = 1'b1;
  logic [7:0] opResult;
  logic [IDX_W-1:0] reqBlock;
  logic [1:0] reqKind;
  logic [AW-1:0] reqAddr;
  logic [4:0] blkShift = 5'd12;
  logic [AW-1:0] rdAddr = '0;

  always #5 clk = ~clk;

  wbt_tracker dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opOffset(opOffset), .opCount(opCount), .opNoErase(opNoErase),
    .winBlocks(winBlocks), .opReady(opReady), .opDone(opDone),
    .opResult(opResult), .reqValid(reqValid), .reqReady(reqReady),
    .reqBlock(reqBlock), .reqKind(reqKind), .reqAddr(reqAddr),
    .blkShift(blkShift), .rdAddr(rdAddr), .rdErased(rdErased)
  );

  int vectors = 0, fails = 0;
  bit finished = 0;
  int markM [MAXB];
  bit lockM [MAXB];
  int qBlk[$], qKind[$];
  bit pendValid = 0, stallOn = 0;
  int pendOp, pendOff, pendCnt, pendRes;
  bit pendNe;
  string pendTag;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int effShift();
    return (blkShift < 5'd12) ? 12 : int'(blkShift);
  endfunction

  function automatic int expResult(int op, int off, int cnt, int win);
    bit lk = 0, mk = 0;
    if (op >= 1 && op <= 3) begin
      if (win > MAXB || off + cnt > win) return 2;
      for (int b = off; b < off + cnt; b++) begin
        if (lockM[b]) lk = 1;
        if (markM[b] != 0) mk = 1;
      end
      if (op == 3) return mk ? 2 : 1;
      return lk ? 9 : 1;
    end
    if (op >= 4) return 1;
    return 2;
  endfunction

  task automatic applyOp(int op, int off, int cnt, bit ne);
    case (op)
      1: for (int b = off; b < off + cnt; b++) markM[b] = ne ? 2 : 1;
      2: for (int b = off; b < off + cnt; b++) markM[b] = 3;
      3: for (int b = off; b < off + cnt; b++) lockM[b] = 1;
      4, 5, 6: for (int b = 0; b < MAXB; b++) markM[b] = 0;
      7: for (int b = 0; b < MAXB; b++) lockM[b] = 0;
      default: ;
    endcase
  endtask

  task automatic tick();
    longint blk;
    bit expEr;
    @(negedge clk);
    reqReady = stallOn ? ($urandom_range(0, 2) != 0) : 1'b1;
    #1;
    if (opDone) begin
      if (!pendValid) chk(0, "R10", "unexpected opDone", 1, 0);
      else begin
        chk(opResult == 8'(pendRes), pendTag, "opResult", opResult, pendRes);
        if (pendRes == 1) applyOp(pendOp, pendOff, pendCnt, pendNe);
        if (pendOp == 4 || pendOp == 5)
          chk(qBlk.size() == 0, "R7", "requests missing at done", qBlk.size(), 0);
        pendValid = 0;
      end
    end
    if (reqValid) begin
      if (!(pendValid && (pendOp == 4 || pendOp == 5)))
        chk(0, "R7", "request outside walk", 1, 0);
      else if (reqReady) begin
        if (qBlk.size() == 0) chk(0, "R7", "extra request block", reqBlock, -1);
        else begin
          chk(reqBlock == IDX_W'(qBlk[0]), "R7", "reqBlock", reqBlock, qBlk[0]);
          chk(reqKind == 2'(qKind[0]), "R7", "reqKind", reqKind, qKind[0]);
          chk(reqAddr == AW'(longint'(qBlk[0]) << effShift()), "R7", "reqAddr",
              reqAddr, longint'(qBlk[0]) << effShift());
          void'(qBlk.pop_front());
          void'(qKind.pop_front());
        end
      end
    end
    blk = longint'(rdAddr) >> effShift();
    expEr = (blk < MAXB) && (markM[int'(blk)] == 3);
    chk(rdErased == expEr, "R6", "rdErased", rdErased, expEr);
  endtask

  task automatic doOp(int op, int off, int cnt, bit ne, string tag, bit intrude = 0);
    int guard = 0;
    opCode = 3'(op); opOffset = CNT_W'(off); opCount = CNT_W'(cnt); opNoErase = ne;
    pendOp = op; pendOff = off; pendCnt = cnt; pendNe = ne; pendTag = tag;
    pendRes = expResult(op, off, cnt, int'(winBlocks));
    qBlk.delete(); qKind.delete();
    if (op == 4 || op == 5)
      for (int b = 0; b < MAXB; b++)
        if (markM[b] != 0 && !lockM[b]) begin
          qBlk.push_back(b);
          qKind.push_back(markM[b] == 1 ? 3 : (markM[b] == 2 ? 2 : 1));
        end
    pendValid = 1;
    opValid = 1'b1;
    tick();
    opValid = 1'b0;
    if (intrude && pendValid) begin
      opCode = 3'd2; opOffset = '0; opCount = 7'd1;   // R10: held while busy
      opValid = 1'b1;
    end
    while (pendValid && guard < 2000) begin
      tick();
      if (!pendValid) opValid = 1'b0;
      guard++;
    end
    opValid = 1'b0;
    if (pendValid) begin
      chk(0, tag, "no opDone", 0, 1);
      pendValid = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R7 watchdog act=150000 exp=<150000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < MAXB; b++) begin markM[b] = 0; lockM[b] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk(opReady == 1'b1, "R1", "opReady", opReady, 1);
    chk(opDone == 1'b0, "R1", "opDone", opDone, 0);
    chk(reqValid == 1'b0, "R1", "reqValid", reqValid, 0);
    chk(rdErased == 1'b0, "R1", "rdErased", rdErased, 0);

    winBlocks = 7'd16;
    doOp(1, 2, 3, 0, "R5");              // blocks 2..4 erase+program
    doOp(2, 8, 2, 0, "R5");              // blocks 8,9 erased
    rdAddr = AW'((8 << 12) + 12'h123); tick();   // R6 hit
    rdAddr = AW'(10 << 12); tick();               // R6 miss
    doOp(1, 5, 1, 1, "R5");              // block 5 program only
    doOp(2, 6, 1, 0, "R5");
    doOp(1, 6, 1, 1, "R5");              // later mark replaces erased
    rdAddr = AW'(6 << 12); tick();
    doOp(2, 14, 3, 0, "R2");             // past window end
    doOp(1, 16, 0, 0, "R2");             // ends exactly at window end
    doOp(3, 15, 1, 0, "R2");             // last block, allowed
    winBlocks = 7'd65;
    doOp(1, 0, 1, 0, "R2");              // window above capacity
    winBlocks = 7'd16;
    doOp(3, 12, 2, 0, "R4");
    doOp(1, 13, 1, 0, "R3");
    doOp(2, 11, 2, 0, "R3");
    doOp(3, 7, 3, 0, "R4");              // covers erased block 8
    doOp(3, 0, 2, 0, "R4");
    doOp(0, 0, 1, 0, "R9");              // unknown opcode
    blkShift = 5'd13; rdAddr = AW'((4 << 13) + 7); tick();   // R6 block 4
    rdAddr = AW'(9 << 13); tick();
    blkShift = 5'd4; rdAddr = AW'(9 << 12); tick();          // R6 shift clamp
    blkShift = 5'd12; rdAddr = AW'((8 << 12) + 1);
    stallOn = 1;
    doOp(4, 0, 0, 0, "R7", 1);           // flush with held op and stalls
    rdAddr = AW'(0); tick(); tick();     // R10: held op left no mark
    doOp(1, 12, 1, 0, "R7");             // locks survive the flush
    doOp(2, 3, 1, 0, "R5");
    doOp(6, 0, 0, 0, "R8");              // discard, no requests
    rdAddr = AW'(3 << 12); tick();
    doOp(4, 0, 0, 0, "R8");              // empty flush
    doOp(7, 0, 0, 0, "R9");
    doOp(1, 12, 1, 0, "R9");             // lock cleared
    doOp(5, 0, 0, 0, "R7");              // close writes block 12
    winBlocks = 7'd64;
    doOp(2, 0, 64, 0, "R5");
    blkShift = 5'd13;
    doOp(4, 0, 0, 0, "R7");              // 64 erase requests
    stallOn = 0;
    doOp(2, 63, 2, 0, "R2");
    doOp(2, 63, 1, 0, "R5");
    rdAddr = AW'(63 << 13); tick();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule